// File: doc/BRIEF.md
# Delayed Write Retry Controller

This block manages a single delayed write held inside a bus bridge. When an initiator on the near bus presents a write, the block takes ownership of it, answers the initiator with retry, and then repeatedly strobes an attempt request toward the far-bus master logic. Each far-bus attempt ends with an encoded termination result. The block turns that result into the response the initiator receives the next time it presents the write.

Retries on the far bus are counted. After `2**CNT_W` consecutive attempts that all end without transferring data, the block stops trying and drops the write. It raises a one-cycle system-error pulse, which can be masked, and answers the initiator's next presentation with a target abort. Two sticky status bits record target aborts: one seen on the far side and one signalled back on the near side. Each bit clears on its own write-one-to-clear pulse.

Top module: `dwr_ctrl`

## Requirements
- R1: After reset, `att_req`, `rsp_valid`, `serr_pulse` and both status bits are 0, and no write is held.
- R2: With no write held, a `req_valid` pulse is accepted. `rsp_valid` is 1 in the following cycle with `rsp_code` 0 (retry). `att_req` is then high for exactly one cycle, starting in that same following cycle.
- R3: While a write is held, every `req_valid` is answered with code 0 (retry) and is not accepted. Its `req_multi` value is not stored.
- R4: An attempt result of 1 (retry) produces a new one-cycle `att_req` in the cycle after the result.
- R5: A result of 0 (normal) or 2 (disconnect) with `att_xfer`=1 ends the attempts. The next `req_valid` is answered with code 2 (disconnect) if the accepted write had `req_multi`=1, and with code 1 (done) otherwise. The slot is then free.
- R6: A result of 0 or 2 with `att_xfer`=0 moved no data. It is treated exactly like a retry: it is counted and a new attempt is issued. Unused result codes 5 to 7 are also treated as retry.
- R7: A result of 3 (target abort) sets `sts_rx_tabort` in the cycle after the result. The next `req_valid` is answered with code 3 (target abort), and `sts_sig_tabort` is set in the cycle after that request.
- R8: A result of 4 (master abort) ends the attempts. The next `req_valid` is answered with code 4, and the slot is freed.
- R9: When the attempt count reaches `2**CNT_W` with every attempt retried, no further `att_req` occurs. The write is dropped, and the next `req_valid` is answered with code 3 and sets `sts_sig_tabort`.
- R10: `serr_pulse` is 1 for exactly one cycle, the cycle after the result that reaches the limit, and only when `serr_en`=1 and `serr_mask`=0.
- R11: Both status bits stay set until their clear input (`clr_rx_tabort`, `clr_sig_tabort`) is 1 at a clock edge. A set and a clear in the same cycle leave the bit set.
- R12: The retry count restarts at zero for every newly accepted write, so each write gets the full `2**CNT_W` attempts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Initiator presents the write (one cycle per presentation) |
| req_multi | input | 1 | Initiator requested more than one data phase |
| att_done | input | 1 | Far-bus attempt result valid |
| att_result | input | 3 | 0 normal, 1 retry, 2 disconnect, 3 target abort, 4 master abort |
| att_xfer | input | 1 | At least one data transfer took place in the attempt |
| serr_en | input | 1 | System-error enable |
| serr_mask | input | 1 | Disable for the retry-limit system error |
| clr_rx_tabort | input | 1 | Write-one-to-clear for the far-side target-abort bit |
| clr_sig_tabort | input | 1 | Write-one-to-clear for the near-side target-abort bit |
| att_req | output | 1 | Strobe requesting one far-bus write attempt |
| rsp_valid | output | 1 | Response to the initiator is valid |
| rsp_code | output | 3 | 0 retry, 1 done, 2 disconnect, 3 target abort, 4 master abort |
| sts_rx_tabort | output | 1 | Sticky: target abort received on the far bus |
| sts_sig_tabort | output | 1 | Sticky: target abort signalled to the initiator |
| serr_pulse | output | 1 | One-cycle system-error pulse on retry-limit drop |

## Verification
The inline properties watch the cycle-level contracts on every clock. They check that the attempt strobe lasts one cycle, that a response appears only after a request, that the system error is a single gated pulse never seen together with an attempt, that the status bits stay set until cleared, and that the retry count holds between retry results and restarts on a new write. Other behaviour can only be shown by the directed scenarios. These cover the mapping from each far-side termination to the initiator's code, the multi-phase distinction between done and disconnect, a zero-data completion counted as a retry, and the exact number of attempts before the drop. They also cover the masked and unmasked system error and the target abort returned after a drop.

// File: rtl/dwr_pkg.sv
package dwr_pkg;

   typedef enum logic [2:0] {
      TR_NORMAL     = 3'd0,
      TR_RETRY      = 3'd1,
      TR_DISCONNECT = 3'd2,
      TR_TABORT     = 3'd3,
      TR_MABORT     = 3'd4
   } far_term_e;

   typedef enum logic [2:0] {
      RSP_RETRY  = 3'd0,
      RSP_DONE   = 3'd1,
      RSP_DISC   = 3'd2,
      RSP_TABORT = 3'd3,
      RSP_MABORT = 3'd4
   } init_rsp_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_HOLD,
      ST_DROPPED
   } dw_state_e;

   typedef struct packed {
      logic again;
      logic done_ok;
      logic tabort;
      logic mabort;
   } term_class_t;

endpackage

// File: rtl/dwr_term_map.sv
module dwr_term_map
   import dwr_pkg::*;
(
   input  logic [2:0]  result,
   input  logic        xfer,
   output term_class_t cls
);

   always_comb begin
      cls = '0;
      case (result)
         TR_NORMAL, TR_DISCONNECT: begin
            cls.done_ok = xfer;
            cls.again   = ~xfer;
         end
         TR_TABORT: cls.tabort = 1'b1;
         TR_MABORT: cls.mabort = 1'b1;
         default:   cls.again  = 1'b1;
      endcase
   end

endmodule

// File: rtl/dwr_retry_cnt.sv
module dwr_retry_cnt #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             bump,
   output logic             limit_hit,
   output logic             terminal,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic at_max;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("dwr_retry_cnt: CNT_W must lie in 2..32");
      end
   endgenerate

   assign at_max    = (count == CNT_MAX);
   assign limit_hit = bump & at_max & ~terminal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         terminal <= 1'b0;
      end else if (clear) begin
         count    <= '0;
         terminal <= 1'b0;
      end else if (bump) begin
         if (at_max) terminal <= 1'b1;
         else        count    <= count + 1'b1;
      end
   end

   AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!bump && !clear) |=> $stable(count)); // R12
   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0 && !terminal)); // R12

endmodule

// File: rtl/dwr_status.sv
module dwr_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_rx,
   input  logic set_sig,
   input  logic clr_rx,
   input  logic clr_sig,
   input  logic limit_evt,
   input  logic serr_en,
   input  logic serr_mask,
   output logic sts_rx,
   output logic sts_sig,
   output logic serr_pulse
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_rx     <= 1'b0;
         sts_sig    <= 1'b0;
         serr_pulse <= 1'b0;
      end else begin
         if (set_rx)      sts_rx  <= 1'b1;
         else if (clr_rx) sts_rx  <= 1'b0;
         if (set_sig)      sts_sig <= 1'b1;
         else if (clr_sig) sts_sig <= 1'b0;
         serr_pulse <= limit_evt & serr_en & ~serr_mask;
      end
   end

   AST_RX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_rx && !clr_rx) |=> sts_rx); // R11
   AST_SIG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_sig && !clr_sig) |=> sts_sig); // R11
   AST_SERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      serr_pulse |=> !serr_pulse); // R10
   AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      serr_pulse |-> ($past(serr_en) && !$past(serr_mask))); // R10

endmodule

// File: rtl/dwr_ctrl.sv
module dwr_ctrl
   import dwr_pkg::*;
#(
   parameter int CNT_W        = 24,
   parameter bit SIG_ON_DROP  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_multi,
   input  logic       att_done,
   input  logic [2:0] att_result,
   input  logic       att_xfer,
   input  logic       serr_en,
   input  logic       serr_mask,
   input  logic       clr_rx_tabort,
   input  logic       clr_sig_tabort,
   output logic       att_req,
   output logic       rsp_valid,
   output logic [2:0] rsp_code,
   output logic       sts_rx_tabort,
   output logic       sts_sig_tabort,
   output logic       serr_pulse
);

   dw_state_e   state_q, state_d;
   term_class_t cls;
   init_rsp_e   hold_code_q, rsp_d;
   logic        multi_q;
   logic        accept, result_ev, bump, limit_hit, terminal;
   logic        set_rx, set_sig, sig_from_drop;
   logic [CNT_W-1:0] retry_count;

   dwr_term_map u_map (
      .result (att_result),
      .xfer   (att_xfer),
      .cls    (cls)
   );

   assign accept    = req_valid && (state_q == ST_IDLE);
   assign result_ev = att_done && (state_q == ST_WAIT);
   assign bump      = result_ev && cls.again;

   dwr_retry_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept),
      .bump      (bump),
      .limit_hit (limit_hit),
      .terminal  (terminal),
      .count     (retry_count)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:    if (req_valid) state_d = ST_ISSUE;
         ST_ISSUE:   state_d = ST_WAIT;
         ST_WAIT: begin
            if (result_ev) begin
               if (!cls.again)     state_d = ST_HOLD;
               else if (limit_hit) state_d = ST_DROPPED;
               else                state_d = ST_ISSUE;
            end
         end
         ST_HOLD, ST_DROPPED: if (req_valid) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      case (state_q)
         ST_HOLD:    rsp_d = hold_code_q;
         ST_DROPPED: rsp_d = RSP_TABORT;
         default:    rsp_d = RSP_RETRY;
      endcase
   end

   generate
      if (SIG_ON_DROP) begin : g_sig_drop
         assign sig_from_drop = (state_q == ST_DROPPED);
      end else begin : g_no_sig_drop
         assign sig_from_drop = 1'b0;
      end
   endgenerate

   assign set_rx  = result_ev && cls.tabort;
   assign set_sig = req_valid &&
                    (((state_q == ST_HOLD) && (hold_code_q == RSP_TABORT)) || sig_from_drop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         hold_code_q <= RSP_RETRY;
         multi_q     <= 1'b0;
         rsp_valid   <= 1'b0;
         rsp_code    <= 3'd0;
      end else begin
         state_q   <= state_d;
         rsp_valid <= req_valid;
         rsp_code  <= req_valid ? rsp_d : 3'd0;
         if (accept) multi_q <= req_multi;
         if (result_ev && !cls.again) begin
            if (cls.done_ok)     hold_code_q <= multi_q ? RSP_DISC : RSP_DONE;
            else if (cls.tabort) hold_code_q <= RSP_TABORT;
            else                 hold_code_q <= RSP_MABORT;
         end
      end
   end

   assign att_req = (state_q == ST_ISSUE);

   dwr_status u_sts (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_rx     (set_rx),
      .set_sig    (set_sig),
      .clr_rx     (clr_rx_tabort),
      .clr_sig    (clr_sig_tabort),
      .limit_evt  (limit_hit),
      .serr_en    (serr_en),
      .serr_mask  (serr_mask),
      .sts_rx     (sts_rx_tabort),
      .sts_sig    (sts_sig_tabort),
      .serr_pulse (serr_pulse)
   );

   AST_ATT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      att_req |=> !att_req); // R2
   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid)); // R2
   AST_NO_ATT_ON_SERR: assert property (@(posedge clk) disable iff (!rst_n)
      serr_pulse |-> !att_req); // R9
   AST_TERMINAL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      terminal |-> !att_req); // R9

endmodule

// File: tb/tb_dwr_ctrl.sv
module tb_dwr_ctrl;

   localparam int CW    = 3;
   localparam int LIMIT = 1 << CW;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0, req_multi = 1'b0;
   logic       att_done = 1'b0, att_xfer = 1'b0;
   logic [2:0] att_result = 3'd0;
   logic       serr_en = 1'b0, serr_mask = 1'b0;
   logic       clr_rx_tabort = 1'b0, clr_sig_tabort = 1'b0;
   logic       att_req, rsp_valid, sts_rx_tabort, sts_sig_tabort, serr_pulse;
   logic [2:0] rsp_code;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   dwr_ctrl #(.CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_multi(req_multi),
      .att_done(att_done), .att_result(att_result), .att_xfer(att_xfer),
      .serr_en(serr_en), .serr_mask(serr_mask),
      .clr_rx_tabort(clr_rx_tabort), .clr_sig_tabort(clr_sig_tabort),
      .att_req(att_req), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
      .sts_rx_tabort(sts_rx_tabort), .sts_sig_tabort(sts_sig_tabort),
      .serr_pulse(serr_pulse)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Present the write for one cycle; returns at the negedge after the edge.
   task automatic present(input logic multi);
      @(negedge clk);
      req_valid = 1'b1;
      req_multi = multi;
      @(negedge clk);
      req_valid = 1'b0;
      req_multi = 1'b0;
   endtask

   // Deliver one far-bus result; returns at the negedge after the edge.
   task automatic far(input logic [2:0] res, input logic xfer);
      @(negedge clk);
      att_done   = 1'b1;
      att_result = res;
      att_xfer   = xfer;
      @(negedge clk);
      att_done   = 1'b0;
      att_result = 3'd0;
      att_xfer   = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 att_req", int'(att_req), 0);
      chk("R1 rsp_valid", int'(rsp_valid), 0);
      chk("R1 serr", int'(serr_pulse), 0);
      chk("R1 sts_rx", int'(sts_rx_tabort), 0);
      chk("R1 sts_sig", int'(sts_sig_tabort), 0);
   endtask

   task automatic t_single_done();
      present(1'b0);
      chk("R2 rsp_valid", int'(rsp_valid), 1);
      chk("R2 rsp retry", int'(rsp_code), 0);
      chk("R2 att_req", int'(att_req), 1);
      present(1'b1);                       // busy presentation, multi not stored
      chk("R3 busy retry", int'(rsp_code), 0);
      chk("R2 strobe one cycle", int'(att_req), 0);
      far(3'd1, 1'b0);
      chk("R4 retry reissues", int'(att_req), 1);
      far(3'd0, 1'b1);
      chk("R5 no attempt after completion", int'(att_req), 0);
      present(1'b0);
      chk("R5 R3 done code", int'(rsp_code), 1);
      present(1'b1);
      chk("R5 slot freed, accepted", int'(att_req), 1);
      far(3'd2, 1'b0);
      chk("R6 zero-data disconnect retried", int'(att_req), 1);
      far(3'd6, 1'b0);
      chk("R6 unused code retried", int'(att_req), 1);
      far(3'd2, 1'b1);
      present(1'b0);
      chk("R5 disconnect code", int'(rsp_code), 2);
   endtask

   task automatic t_tabort();
      present(1'b0);
      far(3'd3, 1'b0);
      chk("R7 rx set", int'(sts_rx_tabort), 1);
      chk("R7 sig not yet", int'(sts_sig_tabort), 0);
      present(1'b1);
      chk("R7 tabort code", int'(rsp_code), 3);
      chk("R7 sig set", int'(sts_sig_tabort), 1);
      repeat (3) @(negedge clk);
      chk("R11 rx held", int'(sts_rx_tabort), 1);
      clr_rx_tabort = 1'b1;
      @(negedge clk);
      clr_rx_tabort = 1'b0;
      chk("R11 rx cleared", int'(sts_rx_tabort), 0);
      chk("R11 sig untouched", int'(sts_sig_tabort), 1);
      clr_sig_tabort = 1'b1;
      @(negedge clk);
      clr_sig_tabort = 1'b0;
      chk("R11 sig cleared", int'(sts_sig_tabort), 0);
      // set and clear together: set wins
      present(1'b0);
      @(negedge clk);
      att_done = 1'b1; att_result = 3'd3; clr_rx_tabort = 1'b1;
      @(negedge clk);
      att_done = 1'b0; att_result = 3'd0; clr_rx_tabort = 1'b0;
      chk("R11 set beats clear", int'(sts_rx_tabort), 1);
      present(1'b0);
      clr_rx_tabort = 1'b1; clr_sig_tabort = 1'b1;
      @(negedge clk);
      clr_rx_tabort = 1'b0; clr_sig_tabort = 1'b0;
   endtask

   task automatic t_mabort();
      present(1'b1);
      far(3'd4, 1'b0);
      chk("R8 no attempt", int'(att_req), 0);
      present(1'b1);
      chk("R8 mabort code", int'(rsp_code), 4);
      chk("R8 no tabort bit", int'(sts_sig_tabort), 0);
      present(1'b0);
      chk("R8 slot freed", int'(att_req), 1);
      far(3'd0, 1'b1);
      present(1'b0);
      chk("R8 follow-up done", int'(rsp_code), 1);
   endtask

   task automatic t_limit(input logic en, input logic mask, input string tag);
      int attempts;
      serr_en = en; serr_mask = mask;
      present(1'b0);
      attempts = 0;
      for (int i = 0; i < LIMIT; i++) begin
         if (att_req) attempts++;
         if (i < LIMIT - 1) begin
            far(3'd1, 1'b0);
            chk({tag, " R10 no early serr"}, int'(serr_pulse), 0);
         end else begin
            far(3'd1, 1'b0);
         end
      end
      chk({tag, " R9 R12 attempt count"}, attempts, LIMIT);
      chk({tag, " R9 stopped"}, int'(att_req), 0);
      chk({tag, " R10 serr"}, int'(serr_pulse), (en && !mask) ? 1 : 0);
      @(negedge clk);
      chk({tag, " R10 serr one cycle"}, int'(serr_pulse), 0);
      repeat (4) begin
         @(negedge clk);
         chk({tag, " R9 idle far bus"}, int'(att_req), 0);
      end
      present(1'b0);
      chk({tag, " R9 tabort after drop"}, int'(rsp_code), 3);
      chk({tag, " R9 sig set"}, int'(sts_sig_tabort), 1);
      clr_sig_tabort = 1'b1;
      @(negedge clk);
      clr_sig_tabort = 1'b0;
      serr_en = 1'b0; serr_mask = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_done();
      t_tabort();
      t_mabort();
      t_limit(1'b1, 1'b0, "unmasked");
      t_limit(1'b1, 1'b1, "masked");
      t_limit(1'b0, 1'b0, "disabled");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule